// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital half of an 8-bit, 8-input successive-approximation converter. A single-cycle start pulse captures an input-channel number and a rate choice. The block then drives the analog front end. It sends a channel code to the input multiplexer, raises a track signal so that the sample-and-hold capacitor follows the chosen input, and presents a trial code to the internal DAC. It reads back one comparator bit for each trial.

Each conversion lasts exactly 27 conversion-clock periods. The first 6 periods track the input. One period lets the held value settle. Eight periods run the binary search from the most significant bit down. The remaining periods are fixed settle and transfer time, and the last of them moves the search register into the result register and raises the done flag. The conversion clock is either the system clock or the system clock divided by two. A start that arrives while a conversion is running abandons that conversion and begins again from tracking.

Top module: `sar_seq_ctrl`

## Requirements
- R1: After reset, busy_o, done_o, hold_o, result_o, dac_o and mux_sel_o are all zero.
- R2: A start latches chan_i. From the next cycle mux_sel_o shows that channel, and it holds that value until the next start.
- R3: hold_o is high for the first 6 conversion clocks after a start. That is 6 system cycles at full rate and 12 at half rate. It is low at all other times.
- R4: done_o rises exactly 27 conversion clocks after the start edge: 27 system cycles when half_rate_i was 0 at start, and 54 when it was 1.
- R5: half_rate_i is sampled only on a start cycle. The value 0 selects the full system clock and 1 selects the system clock divided by two. Changing it mid-conversion has no effect on timing.
- R6: Bits are tried MSB first, in conversion clocks 7 through 14. During trial i (i = 0 for bit 7), dac_o equals the bits already kept OR'd with the bit under test. The bit is kept when cmp_i is 1, meaning the input is at or above the trial level, and cleared otherwise.
- R7: With a comparator that reports input >= dac_o, the result equals the input code across the full range 00h to FFh.
- R8: result_o changes only on the cycle in which done_o rises. It holds its previous value during a conversion. A start clears done_o.
- R9: A start during an active conversion restarts from the track phase on the newly given channel. Completion timing counts from the new start.
- R10: busy_o is high from the cycle after a start until done_o rises, and is never high together with done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin (or restart) a conversion |
| chan_i | input | 3 | Input channel to convert, captured at start |
| half_rate_i | input | 1 | Conversion clock select: 0 full rate, 1 half rate, captured at start |
| cmp_i | input | 1 | Comparator: 1 when held input >= dac_o |
| mux_sel_o | output | 3 | Channel code to the analog multiplexer |
| hold_o | output | 1 | Track control; high while the input is being sampled |
| dac_o | output | 8 | Trial code to the DAC |
| result_o | output | 8 | Last completed conversion result |
| done_o | output | 1 | Result valid; cleared by start |
| busy_o | output | 1 | Conversion in progress |

## Verification
The hardest situation to reach is a restart that lands partway through a conversion at half rate. It must discard the partial search register and the prescaler phase, yet leave the previous result untouched. The stimulus drives a second start at a chosen system cycle inside the trial window, switches the channel and the input level at the same moment, and then checks three things: the new track length, the completion distance from the second start, and that result_o stays stable until the new done. A behavioural comparator reading the bench's channel voltages closes the loop. The trial code is checked at each search step against a bench function that computes the expected partial code.

// File: rtl/sar_pkg.sv
package sar_pkg;
  // phase of the conversion, decoded from the conversion-clock count
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_TRACK  = 3'd1,
    PH_SETTLE = 3'd2,
    PH_TRIAL  = 3'd3,
    PH_TAIL   = 3'd4
  } sar_phase_e;
endpackage

// File: rtl/sar_prescaler.sv
module sar_prescaler (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  input  logic run_i,
  input  logic half_rate_i,
  output logic tick_o
);
  logic phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    if (restart_i)  phase_d = 1'b0;
    else if (run_i) phase_d = ~phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= 1'b0;
    else        phase_q <= phase_d;
  end

  assign tick_o = run_i && !restart_i && (!half_rate_i || phase_q);
endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer #(
  parameter int RES         = 8,
  parameter int CHANNELS    = 8,
  parameter int SAMPLE_CLKS = 6,
  parameter int CONV_CLKS   = 27,
  localparam int CH_W  = $clog2(CHANNELS),
  localparam int CNT_W = $clog2(CONV_CLKS),
  localparam int BIT_W = $clog2(RES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CH_W-1:0]  chan_i,
  input  logic             half_rate_i,
  input  logic             tick_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             slow_o,
  output logic [CH_W-1:0]  chan_o,
  output logic             hold_o,
  output logic             trial_en_o,
  output logic [BIT_W-1:0] bit_idx_o,
  output logic             finish_o
);
  import sar_pkg::*;

  localparam logic [CNT_W-1:0] TRACK_END_C = CNT_W'(SAMPLE_CLKS);
  localparam logic [CNT_W-1:0] TRIAL_LO_C  = CNT_W'(SAMPLE_CLKS + 1);
  localparam logic [CNT_W-1:0] TRIAL_HI_C  = CNT_W'(SAMPLE_CLKS + RES);
  localparam logic [CNT_W-1:0] LAST_C      = CNT_W'(CONV_CLKS - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d, done_q, done_d, slow_q, slow_d;
  logic [CH_W-1:0]  chan_q, chan_d;
  logic [CNT_W-1:0] offs;
  sar_phase_e       phase;

  always_comb begin
    if (!busy_q)                  phase = PH_IDLE;
    else if (cnt_q < TRACK_END_C) phase = PH_TRACK;
    else if (cnt_q < TRIAL_LO_C)  phase = PH_SETTLE;
    else if (cnt_q <= TRIAL_HI_C) phase = PH_TRIAL;
    else                          phase = PH_TAIL;
  end

  assign finish_o = busy_q && tick_i && (cnt_q == LAST_C) && !start_i;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    done_d = done_q;
    chan_d = chan_q;
    slow_d = slow_q;
    if (start_i) begin
      cnt_d  = '0;
      busy_d = 1'b1;
      done_d = 1'b0;
      chan_d = chan_i;
      slow_d = half_rate_i;
    end else if (busy_q && tick_i) begin
      if (finish_o) begin
        cnt_d  = '0;
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      chan_q <= '0;
      slow_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      done_q <= done_d;
      chan_q <= chan_d;
      slow_q <= slow_d;
    end
  end

  assign offs       = cnt_q - TRIAL_LO_C;
  assign trial_en_o = (phase == PH_TRIAL);
  assign bit_idx_o  = BIT_W'(RES - 1) - offs[BIT_W-1:0];
  assign hold_o     = (phase == PH_TRACK);
  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign chan_o     = chan_q;
  assign slow_o     = slow_q;
endmodule

// File: rtl/sar_register.sv
module sar_register #(
  parameter int RES = 8,
  localparam int BIT_W = $clog2(RES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             trial_en_i,
  input  logic             tick_i,
  input  logic [BIT_W-1:0] bit_idx_i,
  input  logic             cmp_i,
  input  logic             finish_i,
  output logic [RES-1:0]   trial_o,
  output logic [RES-1:0]   result_o
);
  logic [RES-1:0] sar_q, sar_d, res_q, res_d, probe;

  always_comb begin
    probe            = '0;
    probe[bit_idx_i] = 1'b1;
  end

  always_comb begin
    sar_d = sar_q;
    res_d = res_q;
    if (clear_i)                    sar_d = '0;
    else if (trial_en_i && tick_i)  sar_d[bit_idx_i] = cmp_i;
    if (finish_i)                   res_d = sar_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sar_q <= '0;
      res_q <= '0;
    end else begin
      sar_q <= sar_d;
      res_q <= res_d;
    end
  end

  assign trial_o  = trial_en_i ? (sar_q | probe) : sar_q;
  assign result_o = res_q;
endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl #(
  parameter int RES         = 8,
  parameter int CHANNELS    = 8,
  parameter int SAMPLE_CLKS = 6,
  parameter int CONV_CLKS   = 27,
  localparam int CH_W  = $clog2(CHANNELS),
  localparam int BIT_W = $clog2(RES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [CH_W-1:0] chan_i,
  input  logic            half_rate_i,
  input  logic            cmp_i,
  output logic [CH_W-1:0] mux_sel_o,
  output logic            hold_o,
  output logic [RES-1:0]  dac_o,
  output logic [RES-1:0]  result_o,
  output logic            done_o,
  output logic            busy_o
);
  logic             tick, slow, trial_en, finish, busy;
  logic [BIT_W-1:0] bit_idx;

  sar_prescaler u_pre (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart_i  (start_i),
    .run_i      (busy),
    .half_rate_i(slow),
    .tick_o     (tick)
  );

  sar_sequencer #(
    .RES(RES), .CHANNELS(CHANNELS),
    .SAMPLE_CLKS(SAMPLE_CLKS), .CONV_CLKS(CONV_CLKS)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .chan_i     (chan_i),
    .half_rate_i(half_rate_i),
    .tick_i     (tick),
    .busy_o     (busy),
    .done_o     (done_o),
    .slow_o     (slow),
    .chan_o     (mux_sel_o),
    .hold_o     (hold_o),
    .trial_en_o (trial_en),
    .bit_idx_o  (bit_idx),
    .finish_o   (finish)
  );

  sar_register #(.RES(RES)) u_sar (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (start_i),
    .trial_en_i(trial_en),
    .tick_i    (tick),
    .bit_idx_i (bit_idx),
    .cmp_i     (cmp_i),
    .finish_i  (finish),
    .trial_o   (dac_o),
    .result_o  (result_o)
  );

  assign busy_o = busy;
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int RES  = 8,
  parameter int CH_W = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start_i,
  input logic [CH_W-1:0] mux_sel_o,
  input logic            hold_o,
  input logic [RES-1:0]  result_o,
  input logic            done_o,
  input logic            busy_o
);
  AST_HOLD_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    hold_o |-> busy_o);  // R3
  AST_CHAN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !start_i) |=> $stable(mux_sel_o));  // R2
  AST_RESULT_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result_o) |-> $rose(done_o));  // R8
  AST_DONE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);  // R10
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (busy_o && !done_o));  // R9
endmodule

bind sar_seq_ctrl sar_seq_chk #(.RES(RES), .CH_W(CH_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start_i  (start_i),
  .mux_sel_o(mux_sel_o),
  .hold_o   (hold_o),
  .result_o (result_o),
  .done_o   (done_o),
  .busy_o   (busy_o)
);

// File: tb/tb_sar_seq_ctrl.sv
module tb_sar_seq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i, half_rate_i, cmp_i;
  logic [2:0] chan_i, mux_sel_o;
  logic       hold_o, done_o, busy_o;
  logic [7:0] dac_o, result_o;
  logic [7:0] vin [0:7];

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  sar_seq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .chan_i(chan_i),
    .half_rate_i(half_rate_i), .cmp_i(cmp_i), .mux_sel_o(mux_sel_o),
    .hold_o(hold_o), .dac_o(dac_o), .result_o(result_o),
    .done_o(done_o), .busy_o(busy_o)
  );

  assign cmp_i = (vin[mux_sel_o] >= dac_o);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected DAC code during trial i: kept upper bits of v plus the bit under test
  function automatic logic [7:0] trial_code(input logic [7:0] v, input int i);
    logic [7:0] keep;
    keep = 8'hFF << (8 - i);
    return (v & keep) | (8'h80 >> i);
  endfunction

  // one conversion; restart_at > 0 issues a second start on new_ch at that cycle
  task automatic convert(input logic [2:0] ch, input bit slow, input int restart_at,
                         input logic [2:0] new_ch, input logic [7:0] new_v);
    int step, n, holds;
    bit restarted, mux_ok, res_ok;
    logic [7:0] prev_res;
    logic [2:0] cur;
    step = slow ? 2 : 1;
    cur = ch;
    prev_res = result_o;
    @(negedge clk);
    start_i = 1'b1; chan_i = ch; half_rate_i = slow;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    half_rate_i = ~slow;                    // R5: ignored mid-conversion
    chan_i = ~ch;
    n = 0; holds = 0; restarted = 0; mux_ok = 1; res_ok = 1;
    while (1) begin
      if (restart_at > 0 && !restarted && n == restart_at) begin
        vin[new_ch] = new_v;
        start_i = 1'b1; chan_i = new_ch; half_rate_i = slow;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0; half_rate_i = ~slow;
        cur = new_ch; n = 0; holds = 0; restarted = 1;
      end
      if (mux_sel_o != cur) mux_ok = 0;
      if (hold_o) holds++;
      if (done_o) break;
      if (result_o != prev_res) res_ok = 0;
      if (!busy_o) begin
        check(0, "R10 busy", 0, 1);
        break;
      end
      for (int i = 0; i < 8; i++)
        if (n == (7 + i) * step)
          check(dac_o == trial_code(vin[cur], i), "R6 trial code", dac_o, trial_code(vin[cur], i));
      if (n > 200) begin
        check(0, "R4 no completion", n, 27 * step);
        break;
      end
      @(posedge clk);
      @(negedge clk);
      n++;
    end
    check(n == 27 * step, "R4 conversion length", n, 27 * step);
    check(holds == 6 * step, "R3 track length", holds, 6 * step);
    check(mux_ok, "R2 channel stable", mux_sel_o, cur);
    check(res_ok, "R8 result held", result_o, prev_res);
    check(result_o == vin[cur], "R7 result", result_o, vin[cur]);
    check(!busy_o && !hold_o, "R10 idle after done", busy_o, 0);
    if (restarted) check(mux_sel_o == new_ch, "R9 restart channel", mux_sel_o, new_ch);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; start_i = 1'b0; chan_i = '0; half_rate_i = 1'b0;
    for (int c = 0; c < 8; c++) vin[c] = 8'(c * 37 + 5);
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!busy_o && !done_o && !hold_o && result_o == 0 && dac_o == 0 && mux_sel_o == 0,
          "R1 reset state", {busy_o, done_o, hold_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed corners: R7 full range at both rates
    vin[0] = 8'h00; convert(3'd0, 1'b0, 0, 3'd0, 8'h00);
    vin[7] = 8'hFF; convert(3'd7, 1'b0, 0, 3'd0, 8'h00);
    vin[3] = 8'h80; convert(3'd3, 1'b1, 0, 3'd0, 8'h00);
    vin[4] = 8'h7F; convert(3'd4, 1'b1, 0, 3'd0, 8'h00);

    // R9: restarts during track, trial and tail phases
    vin[1] = 8'h5A; convert(3'd1, 1'b0, 10, 3'd6, 8'hC3);
    vin[2] = 8'h11; convert(3'd2, 1'b1, 17, 3'd5, 8'h3C);
    vin[2] = 8'hEE; convert(3'd2, 1'b1, 3, 3'd0, 8'hA5);
    vin[5] = 8'h01; convert(3'd5, 1'b0, 25, 3'd5, 8'hFE);

    // R8: start clears done
    @(negedge clk);
    start_i = 1'b1; chan_i = 3'd1; half_rate_i = 1'b0;
    @(posedge clk); @(negedge clk);
    start_i = 1'b0;
    check(!done_o && busy_o, "R8 start clears done", done_o, 0);
    repeat (30) @(negedge clk);

    // random mix
    for (int k = 0; k < 30; k++) begin
      logic [2:0] ch;
      bit sl;
      int ra;
      ch = 3'($urandom_range(0, 7));
      sl = 1'($urandom_range(0, 1));
      for (int c = 0; c < 8; c++) vin[c] = 8'($urandom_range(0, 255));
      ra = ($urandom_range(0, 3) == 0) ? $urandom_range(1, 40) : 0;
      convert(ch, sl, ra, 3'($urandom_range(0, 7)), 8'($urandom_range(0, 255)));
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule